// File: doc/BRIEF.md
# Cartridge ROM Address Latch-Counter

This block is the ROM side of a game cartridge on a bus that uses the same sixteen lines for address and data. The host starts a non-sequential access by putting the low half of a word address on the shared lines and pulling chip select low. The block takes that half into a 16-bit word counter. Each later pulse on the read strobe returns one 16-bit word. The counter steps forward when the strobe rises, so the host can read any number of following words without a new address phase. The upper address byte comes on its own lines and is used as presented.

All bus inputs are brought into the block clock through two-flop synchronisers, and edges are found on the synchronised copies. The block drives the shared lines only while a read is in progress. It gives out a data word and an output-enable, and the pad ring forms the tri-state driver from them. The words come from a small internal array whose contents are computed from the address.

Top module: `cart_rom_front`

## Requirements
- R1: After reset and until the first read, the output-enable `bus_ad_oe` is low.
- R2: When chip select falls, the block takes the value on `bus_ad_in` as the low word address. The first read after that returns the word at that address.
- R3: Every rising edge of the read strobe while chip select is low adds one to the low word address. Each further read returns the word at the next address, with no new chip-select fall.
- R4: The upper address byte is taken from `bus_hi_addr` at read time, not latched. If it changes between sequential reads, the next word uses the new byte together with the incremented low address.
- R5: The low word address wraps from 0xFFFF to 0x0000 and does not carry into the upper byte.
- R6: `bus_ad_oe` is high only while chip select and the read strobe are both low. It stays low in the address phase, when chip select is high, and after the strobe rises.
- R7: A new chip-select fall in the middle of a run of sequential reads discards the counter and loads the new address.
- R8: The word at upper byte H and low address L is P(L mod 2^ARRAY_AW) XOR {H,H}. Here P(k) = (k*0x9E37 + 0x1234) mod 2^16, and ARRAY_AW defaults to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_ad_in | input | 16 | Shared address/data lines as received |
| bus_hi_addr | input | 8 | Upper address byte |
| bus_ad_out | output | 16 | Word to drive onto the shared lines |
| bus_ad_oe | output | 1 | Enable for driving the shared lines |

## Verification
A counter that is off by one, or that fails to wrap, shows up as a wrong word on the very next read strobe. Those words come from different array entries and so cannot be mistaken for the right one. An upper byte that is latched or carried instead of passed through changes the XOR mask, and this shows in the first read after the byte changes, or in the read after the wrap. A faulty enable shows at the ports within three clocks of a strobe or select edge, as a drive during the address phase or as a drive that continues after the strobe rises.

// File: rtl/cart_pkg.sv
package cart_pkg;
   localparam int unsigned DATA_W  = 16;
   localparam int unsigned LO_W    = 16;
   localparam int unsigned HI_W    = 8;
   localparam int unsigned SYNC_N  = 2;

   typedef logic [DATA_W-1:0] word_t;
   typedef logic [LO_W-1:0]   lo_addr_t;
   typedef logic [HI_W-1:0]   hi_addr_t;

   function automatic word_t rom_pattern(input int unsigned k);
      logic [31:0] prod;
      prod = k * 32'h0000_9E37 + 32'h0000_1234;
      return prod[DATA_W-1:0];
   endfunction
endpackage

// File: rtl/cart_sync.sv
module cart_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cart_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= {WIDTH{RST_VAL}};
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cart_addr_ctr.sv
module cart_addr_ctr #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          sel_fall,
   input  logic          strobe_rise,
   input  logic [AW-1:0] ad_cap,
   output logic [AW-1:0] ctr
);
   if (AW < 2) begin : g_bad_aw
      $error("cart_addr_ctr width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ctr <= '0;
      else if (sel_fall)             ctr <= ad_cap;
      else if (strobe_rise && sel)   ctr <= ctr + 1'b1;
   end

   AST_LOAD_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> (ctr == $past(ad_cap))); // R2
   AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_rise && sel && !sel_fall) |=> (ctr == $past(ctr) + 1'b1)); // R3
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_fall && !(strobe_rise && sel)) |=> $stable(ctr)); // R3
endmodule

// File: rtl/cart_rom_array.sv
module cart_rom_array
   import cart_pkg::*;
#(
   parameter int unsigned ARRAY_AW = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  lo_addr_t   lo,
   input  hi_addr_t   hi,
   output word_t      dout
);
   localparam int unsigned DEPTH = 1 << ARRAY_AW;

   if (ARRAY_AW < 1 || ARRAY_AW > LO_W) begin : g_bad_depth
      $error("cart_rom_array depth out of range");
   end
   if (2 * HI_W != DATA_W) begin : g_bad_mask
      $error("upper byte mask must fill the data word");
   end

   word_t mem [DEPTH];

   for (genvar i = 0; i < int'(DEPTH); i++) begin : g_fill
      assign mem[i] = rom_pattern(i);
   end

   logic [ARRAY_AW-1:0] idx;
   assign idx = lo[ARRAY_AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else        dout <= mem[idx] ^ {hi, hi};
   end
endmodule

// File: rtl/cart_rom_front.sv
module cart_rom_front
   import cart_pkg::*;
#(
   parameter int unsigned ARRAY_AW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_cs_n,
   input  logic        bus_rd_n,
   input  logic [15:0] bus_ad_in,
   input  logic [7:0]  bus_hi_addr,
   output logic [15:0] bus_ad_out,
   output logic        bus_ad_oe
);
   logic     cs_n_s, rd_n_s, cs_n_d, rd_n_d;
   lo_addr_t ad_s, ctr;
   hi_addr_t hi_s;

   cart_sync #(.WIDTH(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_cs_n), .q(cs_n_s));
   cart_sync #(.WIDTH(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_rd_n), .q(rd_n_s));
   cart_sync #(.WIDTH(LO_W), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_ad_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ad_in), .q(ad_s));
   cart_sync #(.WIDTH(HI_W), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_hi_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_hi_addr), .q(hi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_d <= 1'b1;
         rd_n_d <= 1'b1;
      end else begin
         cs_n_d <= cs_n_s;
         rd_n_d <= rd_n_s;
      end
   end

   logic sel, sel_fall, strobe_rise;
   assign sel         = !cs_n_s;
   assign sel_fall    = cs_n_d && !cs_n_s;
   assign strobe_rise = !rd_n_d && rd_n_s;

   cart_addr_ctr #(.AW(LO_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .sel(sel), .sel_fall(sel_fall),
      .strobe_rise(strobe_rise), .ad_cap(ad_s), .ctr(ctr));

   cart_rom_array #(.ARRAY_AW(ARRAY_AW)) u_rom (
      .clk(clk), .rst_n(rst_n), .lo(ctr), .hi(hi_s), .dout(bus_ad_out));

   assign bus_ad_oe = sel && !rd_n_s;

   AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ad_oe) |-> (!$past(bus_cs_n, 2) && !$past(bus_rd_n, 2))); // R6
   AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ad_oe && $past(bus_cs_n, 2)) |-> 1'b0); // R6
endmodule

// File: tb/cart_rom_front_test.sv
module cart_rom_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int AAW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic [15:0] ad_in = 16'h0000;
   logic [7:0]  hi = 8'h00;
   logic [15:0] ad_out;
   logic        oe;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cart_rom_front #(.ARRAY_AW(AAW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n),
      .bus_ad_in(ad_in), .bus_hi_addr(hi), .bus_ad_out(ad_out), .bus_ad_oe(oe));

   function automatic logic [15:0] expect_word(input logic [7:0] h, input logic [15:0] lo);
      logic [31:0] p;
      int unsigned k;
      k = lo % (1 << AAW);
      p = k * 32'd40503 + 32'd4660;
      return p[15:0] ^ {h, h};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic addr_phase(input logic [7:0] h, input logic [15:0] lo);
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1; ad_in = lo; hi = h;
      wait_n(4);
      cs_n = 1'b0;
      wait_n(6);
      check("R6 address phase", {15'd0, oe}, 16'd0);
      ad_in = ~lo;
   endtask

   task automatic read_one(input string req, input logic [15:0] exp);
      @(negedge clk);
      rd_n = 1'b0;
      wait_n(6);
      check("R6 drive during read", {15'd0, oe}, 16'd1);
      check(req, ad_out, exp);
      rd_n = 1'b1;
      wait_n(6);
      check("R6 release after strobe", {15'd0, oe}, 16'd0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(4);
      check("R1 reset enable", {15'd0, oe}, 16'd0);
   endtask

   task automatic t_sequential;
      addr_phase(8'h12, 16'h0005);
      for (int i = 0; i < 5; i++)
         read_one((i == 0) ? "R2 R8 first word" : "R3 sequential word",
                  expect_word(8'h12, 16'h0005 + 16'(i)));
   endtask

   task automatic t_hi_change;
      addr_phase(8'h40, 16'h0A10);
      read_one("R2 word", expect_word(8'h40, 16'h0A10));
      hi = 8'hC3;
      read_one("R4 new upper byte", expect_word(8'hC3, 16'h0A11));
   endtask

   task automatic t_wrap;
      addr_phase(8'h34, 16'hFFFE);
      read_one("R5 word FFFE", expect_word(8'h34, 16'hFFFE));
      read_one("R5 word FFFF", expect_word(8'h34, 16'hFFFF));
      read_one("R5 wrap to 0000", expect_word(8'h34, 16'h0000));
   endtask

   task automatic t_reload;
      addr_phase(8'h07, 16'h0020);
      read_one("R3 word", expect_word(8'h07, 16'h0020));
      read_one("R3 word", expect_word(8'h07, 16'h0021));
      addr_phase(8'h07, 16'h0090);
      read_one("R7 reload", expect_word(8'h07, 16'h0090));
   endtask

   task automatic t_deselected_strobe;
      @(negedge clk);
      cs_n = 1'b1;
      wait_n(4);
      rd_n = 1'b0;
      wait_n(6);
      check("R6 strobe without select", {15'd0, oe}, 16'd0);
      rd_n = 1'b1;
      wait_n(4);
   endtask

   initial begin
      t_reset;
      t_sequential;
      t_hi_change;
      t_wrap;
      t_reload;
      t_deselected_strobe;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog actual %h expected %h", 16'd1, 16'd0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule